// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block turns parallel bytes into asynchronous serial frames and turns received serial frames back into bytes. A single 16-bit divisor sets the bit rate for both directions. Each bit lasts sixteen sub-ticks, and each sub-tick lasts divisor-plus-one clocks. A 5-bit format word selects the frame layout: 7 or 8 data bits, an optional parity bit that is even or odd, and one or two stop bits. Data bits travel least significant first.

The receiver keeps one decoded character in a holding register. The host takes it with a pop strobe. Every pop loads the error flags of the popped character (parity, framing, overrun) into a status byte. That status byte also shows whether the transmitter is fully idle.

A global enable freezes both shifters in place and parks the serial output high. Separate enables for receive and transmit control whether a new frame may start. A level soft reset returns the engine to its idle state. FIFOs, interrupt generation and bus decoding sit in neighbouring blocks.

Top module: `uart_frame_engine`

## Requirements
- R1: With divisor value N on `baudDiv`, every transmitted bit lasts exactly 16 × (N + 1) clock cycles, measured from the cycle that accepts the byte.
- R2: A transmitted frame has this layout:
  - a low start bit;
  - the data bits, least significant first; there are 8 of them when `frameCfg[0]`=1 and 7 otherwise, and in 7-bit mode `txData[7]` is ignored;
  - a parity bit when `frameCfg[2]`=1, chosen so that the data bits plus the parity bit hold an even number of ones, or an odd number when `frameCfg[4]`=1;
  - one stop bit, or two when `frameCfg[1]`=1, with the line high.
- R3: A frame in the R2 layout on `rxLine` is delivered on `rxData` with `rxValid` high until it is popped. In 7-bit mode `rxData[7]` reads 0.
- R4: A popped character whose parity bit does not match the R2 rule sets `status[0]`. With parity disabled, `status[0]` stays 0.
- R5: A popped character whose sampled stop bit (either of two) was low sets `status[1]`.
- R6: A frame that completes while the holding register is full, with no pop in the same cycle, is discarded. The held character stays unchanged. Popping that held character sets `status[2]`.
- R7: `status[2:0]` changes only on a pop that finds a character in the holding register, or on soft reset. A pop while `rxValid` is 0 leaves the status unchanged.
- R8: `status[6]` is 1 exactly when the transmitter is idle. `txReady` is high only when the transmitter is idle, `txEnable` and `blkEnable` are 1, and `softReset` is 0.
- R9: The receiver confirms a start bit half a bit after the falling edge. A low pulse shorter than half a bit produces no character.
- R10: With `rxEnable`=0 no new frame is received. With `txEnable`=0 no byte is accepted and `txLine` stays high.
- R11: While `blkEnable`=0, `txLine` is high and both shifters hold their state. After re-enable, the frame resumes, so the frame takes its normal length plus the disabled cycles.
- R12: While `softReset`=1, the holding register is emptied, `status` reads 0x40 and `txLine` is high.
- R13: A pop in the same cycle that a frame completes removes the old character and stores the new one, without flagging an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blkEnable | input | 1 | Global enable; 0 freezes the engine and parks the line high |
| rxEnable | input | 1 | Allows new receive frames to start |
| txEnable | input | 1 | Allows new transmit bytes to be accepted |
| softReset | input | 1 | Level soft reset of the engine state |
| frameCfg | input | 5 | Format word: [0] 8-bit, [1] two stop bits, [2] parity on, [4] odd parity |
| baudDiv | input | 16 | Sub-tick length minus one, in clocks |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | `txData` offered this cycle |
| txReady | output | 1 | Byte accepted when `txValid` and `txReady` are both high |
| txLine | output | 1 | Serial output |
| rxLine | input | 1 | Serial input, asynchronous |
| rxData | output | 8 | Held received character |
| rxValid | output | 1 | Holding register full |
| rxPop | input | 1 | Take the held character and refresh the error flags |
| status | output | 8 | [0] parity error, [1] framing error, [2] overrun, [6] transmitter idle |

## Verification
A pop from the host and the completion of a received frame can land in the same clock cycle. There, the holding register must release the old character and capture the new one at once, and no overrun may be recorded. The bench first measures, with the register empty, how many cycles separate the start of a frame from `rxValid` rising. It then refills the register and repeats the same frame with the pop placed on the completion cycle. The bench judges the result by the character left in the register, by the status after that pop, and by the status after the following pop, which must show no overrun.

// File: rtl/ufe_pkg.sv
package ufe_pkg;
  localparam int CFG_LEN8  = 0;
  localparam int CFG_STOP2 = 1;
  localparam int CFG_PAR   = 2;
  localparam int CFG_ODD   = 4;
  localparam int FRAME_MAX = 12;
  localparam int RXBITS    = FRAME_MAX - 1;

  typedef struct packed {
    logic       txLoad;
    logic       txShift;
    logic       rxSample;
    logic [3:0] rxIdx;
    logic       rxDone;
  } ufe_strobe_t;

  function automatic logic [3:0] frameBits(input logic [4:0] cfg);
    return 4'd9 + {3'b0, cfg[CFG_LEN8]} + {3'b0, cfg[CFG_PAR]} + {3'b0, cfg[CFG_STOP2]};
  endfunction
endpackage

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl import ufe_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             softReset,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic             txValid,
  input  logic [4:0]       cfg,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxSync,
  output ufe_strobe_t      strb,
  output logic             txReady,
  output logic             txBusy
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_DONE} rx_state_t;

  logic [3:0]       frameLen;
  logic [DIV_W-1:0] txPre, rxPre;
  logic [SUB_W-1:0] txSub, rxSub;
  logic [3:0]       txBit, rxBit;
  logic             txTick, rxTick;
  rx_state_t        rxState;

  assign frameLen = frameBits(cfg);
  assign txTick   = txBusy && (txPre == divisor);
  assign rxTick   = (rxState == RX_START || rxState == RX_DATA) && (rxPre == divisor);
  assign txReady  = !txBusy && txEnable && run && !softReset;

  always_comb begin
    strb          = '0;
    strb.txLoad   = txReady && txValid;
    strb.txShift  = run && txTick && (txSub == SUB_LAST);
    strb.rxSample = run && (rxState == RX_DATA) && rxTick && (rxSub == SUB_LAST);
    strb.rxIdx    = rxBit;
    strb.rxDone   = run && (rxState == RX_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBusy <= 1'b0; txPre <= '0; txSub <= '0; txBit <= '0;
    end else if (softReset) begin
      txBusy <= 1'b0; txPre <= '0; txSub <= '0; txBit <= '0;
    end else if (run) begin
      if (strb.txLoad) begin
        txBusy <= 1'b1; txPre <= '0; txSub <= '0; txBit <= '0;
      end else if (txBusy) begin
        if (txTick) begin
          txPre <= '0;
          txSub <= (txSub == SUB_LAST) ? '0 : txSub + 1'b1;
          if (txSub == SUB_LAST) begin
            txBit <= txBit + 1'b1;
            if (txBit == frameLen - 4'd1) txBusy <= 1'b0;
          end
        end else begin
          txPre <= txPre + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxState <= RX_IDLE; rxPre <= '0; rxSub <= '0; rxBit <= '0;
    end else if (softReset) begin
      rxState <= RX_IDLE; rxPre <= '0; rxSub <= '0; rxBit <= '0;
    end else if (run) begin
      case (rxState)
        RX_IDLE: if (rxEnable && !rxSync) begin
          rxState <= RX_START; rxPre <= '0; rxSub <= '0; rxBit <= '0;
        end
        RX_START, RX_DATA: begin
          if (rxTick) begin
            rxPre <= '0;
            rxSub <= (rxSub == SUB_LAST) ? '0 : rxSub + 1'b1;
            if (rxState == RX_START && rxSub == SUB_MID) begin
              rxSub   <= '0;
              rxState <= rxSync ? RX_IDLE : RX_DATA;
            end else if (rxState == RX_DATA && rxSub == SUB_LAST) begin
              rxBit <= rxBit + 1'b1;
              if (rxBit == frameLen - 4'd2) rxState <= RX_DONE;
            end
          end else begin
            rxPre <= rxPre + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_datapath.sv
module uart_fe_datapath import ufe_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        softReset,
  input  logic [4:0]  cfg,
  input  ufe_strobe_t strb,
  input  logic [7:0]  txData,
  input  logic        rxLine,
  input  logic        rxPop,
  output logic        rxSync,
  output logic        txLine,
  output logic [7:0]  rxData,
  output logic        rxValid,
  output logic [2:0]  errBits
);
  logic [FRAME_MAX-1:0] txSh, txFrame;
  logic [RXBITS-1:0]    rxBits;
  logic [1:0]           syncQ;
  logic [7:0]           rxByte;
  logic                 parBad, frmBad, popOk;
  logic                 bufPar, bufFrm, bufOvr;
  int                   dw, stopPos;

  assign dw      = cfg[CFG_LEN8] ? 8 : 7;
  assign stopPos = dw + int'(cfg[CFG_PAR]);

  always_comb begin
    logic [7:0] d;
    d       = cfg[CFG_LEN8] ? txData : {1'b0, txData[6:0]};
    txFrame = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < dw) txFrame[1 + i] = d[i];
    if (cfg[CFG_PAR]) txFrame[1 + dw] = (^d) ^ cfg[CFG_ODD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              txSh <= '1;
    else if (softReset)      txSh <= '1;
    else if (strb.txLoad)    txSh <= txFrame;
    else if (strb.txShift)   txSh <= {1'b1, txSh[FRAME_MAX-1:1]};
  end
  assign txLine = run ? txSh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         syncQ <= 2'b11;
    else if (softReset) syncQ <= 2'b11;
    else                syncQ <= {syncQ[0], rxLine};
  end
  assign rxSync = syncQ[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rxBits <= '1;
    else if (softReset)     rxBits <= '1;
    else if (strb.rxSample) rxBits[strb.rxIdx] <= rxSync;
  end

  always_comb begin
    rxByte = cfg[CFG_LEN8] ? rxBits[7:0] : {1'b0, rxBits[6:0]};
    parBad = cfg[CFG_PAR] && (((^rxByte) ^ rxBits[dw]) != cfg[CFG_ODD]);
    frmBad = !rxBits[stopPos] || (cfg[CFG_STOP2] && !rxBits[stopPos + 1]);
  end

  assign popOk = rxPop && rxValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || softReset) begin
      rxValid <= 1'b0; rxData <= '0; bufPar <= 1'b0; bufFrm <= 1'b0;
      bufOvr  <= 1'b0; errBits <= '0;
    end else begin
      if (popOk) errBits <= {bufOvr, bufFrm, bufPar};
      if (strb.rxDone) begin
        if (!rxValid || popOk) begin
          rxValid <= 1'b1; rxData <= rxByte;
          bufPar  <= parBad; bufFrm <= frmBad; bufOvr <= 1'b0;
        end else begin
          bufOvr <= 1'b1;
        end
      end else if (popOk) begin
        rxValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine import ufe_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blkEnable,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic             softReset,
  input  logic [4:0]       frameCfg,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             txLine,
  input  logic             rxLine,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxPop,
  output logic [7:0]       status
);
  ufe_strobe_t strb;
  logic        rxSync, txBusy;
  logic [2:0]  errBits;

  uart_fe_ctrl #(.DIV_W(DIV_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(blkEnable), .softReset(softReset),
    .rxEnable(rxEnable), .txEnable(txEnable), .txValid(txValid),
    .cfg(frameCfg), .divisor(baudDiv), .rxSync(rxSync),
    .strb(strb), .txReady(txReady), .txBusy(txBusy)
  );

  uart_fe_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .run(blkEnable), .softReset(softReset),
    .cfg(frameCfg), .strb(strb), .txData(txData), .rxLine(rxLine),
    .rxPop(rxPop), .rxSync(rxSync), .txLine(txLine), .rxData(rxData),
    .rxValid(rxValid), .errBits(errBits)
  );

  assign status = {1'b0, !txBusy, 3'b000, errBits};
endmodule

// File: rtl/uart_fe_checker.sv
module uart_fe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       blkEnable,
  input logic       softReset,
  input logic       rxPop,
  input logic       txReady,
  input logic       txLine,
  input logic       rxValid,
  input logic [7:0] rxData,
  input logic [7:0] status
);
  AST_LINE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !blkEnable |-> txLine); // R11
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    txReady |-> status[6]); // R8
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> (!rxValid && status == 8'h40)); // R12
  AST_HELD_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && !rxPop && !softReset) |=> (rxValid && $stable(rxData))); // R6
  AST_ERR_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxPop && !softReset) |=> $stable(status[2:0])); // R7
  AST_FROZEN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (!blkEnable && !softReset) |=> $stable(status[6])); // R11
endmodule

bind uart_frame_engine uart_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .blkEnable(blkEnable), .softReset(softReset),
  .rxPop(rxPop), .txReady(txReady), .txLine(txLine), .rxValid(rxValid),
  .rxData(rxData), .status(status)
);

// File: tb/tb_uart_frame_engine.sv
module tb_uart_frame_engine;
  logic clk = 0, rst_n = 0;
  logic blkEnable = 1, rxEnable = 0, txEnable = 0, softReset = 0;
  logic [4:0] frameCfg = 5'b00001;
  logic [15:0] baudDiv = 16'd0;
  logic [7:0] txData = 0;
  logic txValid = 0, rxLine = 1, rxPop = 0;
  logic txReady, txLine, rxValid;
  logic [7:0] rxData, status;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_frame_engine dut (.*);

  function automatic int bitP();
    return 16 * (int'(baudDiv) + 1);
  endfunction

  function automatic int expLen(input logic [4:0] c);
    return 1 + (c[0] ? 8 : 7) + c[2] + 1 + c[1];
  endfunction

  function automatic logic [11:0] expFrame(input logic [4:0] c, input logic [7:0] d);
    logic [11:0] f;
    int w, k;
    w = c[0] ? 8 : 7;
    f = '1;
    f[0] = 1'b0;
    k = 0;
    for (int i = 0; i < w; i++) f[1 + i] = d[i];
    if (c[2]) begin
      for (int i = 0; i < w; i++) k += d[i];
      f[1 + w] = (k % 2 == 1) ^ c[4];
    end
    return f;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input bit badPar, input bit badStop);
    logic [11:0] f;
    int w;
    w = frameCfg[0] ? 8 : 7;
    f = expFrame(frameCfg, d);
    if (badPar && frameCfg[2]) f[1 + w] = ~f[1 + w];
    if (badStop) f[1 + w + frameCfg[2]] = 1'b0;
    for (int i = 0; i < expLen(frameCfg); i++) begin
      rxLine = f[i];
      nclk(bitP());
    end
    rxLine = 1'b1;
  endtask

  task automatic pop();
    rxPop = 1; nclk(1); rxPop = 0;
  endtask

  task automatic txSendCheck(input logic [7:0] d, input string tag);
    logic [11:0] f;
    int bad;
    f = expFrame(frameCfg, d);
    bad = 0;
    while (!txReady) nclk(1);
    txData = d; txValid = 1; nclk(1); txValid = 0;
    nclk(bitP() / 2);
    for (int i = 0; i < expLen(frameCfg); i++) begin
      if (txLine !== f[i]) bad++;
      if (i < expLen(frameCfg) - 1) nclk(bitP());
    end
    check(bad == 0, tag, bad, 0);
    while (!status[6]) nclk(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int cnt, m, bad;
    logic [7:0] d;
    logic [7:0] expS;
    bit bp, bs;
    void'($urandom(32'd1234));
    nclk(3); rst_n = 1; nclk(1);
    check(status == 8'h40 && !rxValid && txLine && !txReady, "R8 reset state", status, 8'h40);
    softReset = 1; nclk(1); softReset = 0; rxEnable = 1; txEnable = 1; nclk(1);
    check(txReady == 1, "R8 ready after enables", txReady, 1);

    // R1: bit period from divisor, start bit measured with d0=1
    baudDiv = 3; frameCfg = 5'b00001;
    while (!txReady) nclk(1);
    txData = 8'h01; txValid = 1; nclk(1); txValid = 0;
    cnt = 0;
    while (txLine == 0) begin cnt++; nclk(1); end
    check(cnt == 64, "R1 start bit length", cnt, 64);
    while (!status[6]) nclk(1);

    // R2 R3 R4 R5: random formats, bytes and errors
    for (int it = 0; it < 20; it++) begin
      frameCfg = {$urandom_range(0, 1) == 1, 1'b0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1};
      baudDiv = 16'($urandom_range(0, 2));
      d = 8'($urandom);
      txSendCheck(d, "R2 tx frame");
      bp = ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 4) == 0);
      sendRx(d, bp, bs);
      d = frameCfg[0] ? d : {1'b0, d[6:0]};
      check(rxValid && rxData == d, "R3 rx data", rxData, d);
      pop();
      expS = 8'h40 | (bs ? 8'h02 : 8'h00) | ((bp && frameCfg[2]) ? 8'h01 : 8'h00);
      check(status == expS, "R4 R5 status after pop", status, expS);
      nclk(bitP());
    end

    // R10: receive and transmit enables
    frameCfg = 5'b00001; baudDiv = 1;
    rxEnable = 0; sendRx(8'h3C, 0, 0); nclk(bitP());
    check(rxValid == 0, "R10 rx disabled ignores frame", rxValid, 0);
    rxEnable = 1; txEnable = 0; nclk(1);
    check(txReady == 0, "R10 tx disabled not ready", txReady, 0);
    txData = 8'h00; txValid = 1; bad = 0;
    for (int i = 0; i < 40; i++) begin nclk(1); if (!txLine || !status[6]) bad++; end
    txValid = 0; txEnable = 1;
    check(bad == 0, "R10 tx disabled line idle", bad, 0);

    // R9: short start glitch rejected
    baudDiv = 3;
    rxLine = 0; nclk(16); rxLine = 1; nclk(2 * bitP());
    check(rxValid == 0, "R9 glitch rejected", rxValid, 0);
    sendRx(8'h5A, 0, 0);
    check(rxValid && rxData == 8'h5A, "R9 frame after glitch", rxData, 8'h5A);
    pop(); nclk(bitP());

    // R6: overrun
    baudDiv = 0; frameCfg = 5'b00111;
    sendRx(8'hA1, 0, 0); nclk(bitP());
    sendRx(8'hB2, 0, 0); nclk(bitP());
    check(rxValid && rxData == 8'hA1, "R6 held char kept", rxData, 8'hA1);
    pop();
    check(status == 8'h44 && !rxValid, "R6 overrun on pop", status, 8'h44);
    sendRx(8'hC3, 0, 0); pop();
    check(status == 8'h40, "R6 overrun cleared next char", status, 8'h40);
    nclk(bitP());

    // R13: pop in the completion cycle
    fork
      sendRx(8'h11, 0, 0);
      begin m = 0; while (!rxValid) begin nclk(1); m++; end end
    join
    pop(); nclk(bitP());
    sendRx(8'h22, 0, 0); nclk(bitP());
    fork
      sendRx(8'h33, 0, 0);
      begin nclk(m - 1); rxPop = 1; nclk(1); rxPop = 0; end
    join
    check(rxValid && rxData == 8'h33, "R13 new char stored", rxData, 8'h33);
    check(status == 8'h40, "R13 popped char clean", status, 8'h40);
    pop();
    check(status == 8'h40, "R13 no overrun flagged", status, 8'h40);
    nclk(bitP());

    // R4 R7: error visible, empty pop leaves status
    sendRx(8'h44, 1, 0); pop();
    check(status == 8'h41, "R4 parity error", status, 8'h41);
    pop();
    check(status == 8'h41, "R7 empty pop ignored", status, 8'h41);
    nclk(bitP());

    // R11: global enable pause mid-frame
    frameCfg = 5'b00001; baudDiv = 0;
    while (!txReady) nclk(1);
    txData = 8'h00; txValid = 1; nclk(1); txValid = 0;
    cnt = 0; bad = 0;
    while (!status[6] && cnt < 1000) begin
      if (cnt > 20 && cnt <= 50 && txLine !== 1'b1) bad++;
      if (cnt == 20) blkEnable = 0;
      if (cnt == 50) blkEnable = 1;
      cnt++; nclk(1);
    end
    check(bad == 0, "R11 line high while disabled", bad, 0);
    check(cnt == 190, "R11 frame resumes after pause", cnt, 190);

    // R12: soft reset mid-activity
    sendRx(8'h66, 0, 0);
    while (!txReady) nclk(1);
    txData = 8'h00; txValid = 1; nclk(1); txValid = 0; nclk(20);
    softReset = 1; nclk(2);
    check(status == 8'h40 && !rxValid, "R12 status and buffer cleared", status, 8'h40);
    check(txLine == 1 && !txReady, "R12 line idle while held", txLine, 1);
    softReset = 0; nclk(1);
    check(txReady == 1, "R12 ready after release", txReady, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule